// File: doc/BRIEF.md
# Timed Reset Control Sequencer

This block turns a write to a reset-control register into a timed sequence on a set of active-low reset lines. The register logic presents a one-cycle write strobe with a 5-bit command. Bit 4 announces that sleep is about to be entered. Bits 3..0 each select a kind of reset: power-off, full reboot, normal reboot and memory-only reset. Each kind pulls a different subset of the outputs low. A normal reboot also pulls the memory reset when the legacy-emulation status input is high at the time of the write.

After a reset write, the selected lines are held for a fixed number of millisecond ticks (`msTick`, default 5) and are then released together. A second, longer count (default 100 ticks) then runs, and at its end the block emits a one-cycle register re-initialization pulse. `busy` stays high from the write until that pulse. Any write that arrives while `busy` is high is discarded.

Top module: `reset_sequencer`

## Requirements
- R1: Out of reset, `socRstN`, `secRstN` and `memRstN` are high, and `powerOffReq`, `sleepNotify`, `reinitPulse` and `busy` are low.
- R2: Command bit 1 (full reboot) drives both `socRstN` and `secRstN` low.
- R3: Command bit 2 (normal reboot) drives `secRstN` low. It also drives `memRstN` low when `legacyMode` was high in the write cycle. Later changes of `legacyMode` have no effect on that sequence.
- R4: Command bit 3 drives only `memRstN` low.
- R5: Command bit 0 (power-off) raises `powerOffReq` for the hold window, like a reset line.
- R6: Command bit 4 gives a one-cycle `sleepNotify` pulse in the cycle after the write. On its own it asserts no line and does not raise `busy`.
- R7: The selected lines change in the cycle after the accepted write. They are released together in the cycle after the 5th `msTick` sampled after the write cycle. A tick in the write cycle itself does not count.
- R8: One cycle after the 100th `msTick` that follows the release cycle, `reinitPulse` is high for one cycle and `busy` falls.
- R9: `busy` is high from the cycle after an accepted reset write until the re-initialization pulse. A write while `busy` is high changes nothing.
- R10: Several reset bits in one write assert the union of their lines, and these lines share one hold and one release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWrite | input | 1 | One-cycle command write strobe |
| cmdData | input | 5 | Command bits: 0 power-off, 1 full reboot, 2 normal reboot, 3 memory reset, 4 sleep notice |
| msTick | input | 1 | One-cycle millisecond timebase tick |
| legacyMode | input | 1 | Legacy emulation mode status |
| socRstN | output | 1 | Main SoC reset, active low |
| secRstN | output | 1 | Secondary reset, active low |
| memRstN | output | 1 | Memory reset, active low |
| powerOffReq | output | 1 | Power-off request, active high |
| sleepNotify | output | 1 | One-cycle sleep notice |
| reinitPulse | output | 1 | One-cycle register re-initialization pulse |
| busy | output | 1 | Sequence in progress |

## Verification
Every output is registered. The line states, `busy` and `sleepNotify` therefore change one cycle after the accepted write. Release comes one cycle after the fifth counted tick, and `reinitPulse` one cycle after the hundredth tick that follows the release. The bench runs a behavioural model that updates on every rising edge from the same sampled inputs. It compares all seven outputs with the model at the following falling edge. Directed checks wait on a bench-side count of ticks seen at rising edges and sample at the falling edge just after the deciding tick. This catches an off-by-one in either window.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;

  // command bit positions (the decode depends on them)
  localparam int CMD_PWR   = 0;
  localparam int CMD_FULL  = 1;
  localparam int CMD_NORM  = 2;
  localparam int CMD_MEM   = 3;
  localparam int CMD_SLEEP = 4;
  localparam int CMD_W     = 5;
  localparam int RST_BITS  = CMD_SLEEP;

  // internal line indices, all active high inside the block
  localparam int LINE_SOC  = 0;
  localparam int LINE_SEC  = 1;
  localparam int LINE_MEM  = 2;
  localparam int LINE_PWR  = 3;
  localparam int NUM_LINES = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadLines;
    logic relLines;
    logic reinitGo;
    logic sleepGo;
  } seqStrobe_t;

endpackage

// File: rtl/reset_seq_ctrl.sv
module reset_seq_ctrl
  import reset_seq_pkg::*;
#(
  parameter int HOLD_MS   = 5,
  parameter int REINIT_MS = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             msTick,
  output seqStrobe_t       strb,
  output logic             busy
);

  localparam int MAX_MS = (REINIT_MS > HOLD_MS) ? REINIT_MS : HOLD_MS;
  localparam int CNT_W  = $clog2(MAX_MS + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_MS - 1);
  localparam logic [CNT_W-1:0] REINIT_LAST = CNT_W'(REINIT_MS - 1);

  seqState_t        state, stateNxt;
  logic [CNT_W-1:0] msCnt, msCntNxt;
  logic             accept, anyReset, holdDone, waitDone;

  assign accept   = cmdWrite && (state == ST_IDLE);
  assign anyReset = |cmdData[RST_BITS-1:0];
  assign holdDone = (state == ST_HOLD) && msTick && (msCnt == HOLD_LAST);
  assign waitDone = (state == ST_WAIT) && msTick && (msCnt == REINIT_LAST);

  always_comb begin
    stateNxt      = state;
    msCntNxt      = msCnt;
    strb          = '0;
    strb.sleepGo  = accept && cmdData[CMD_SLEEP];
    unique case (state)
      ST_IDLE: begin
        if (accept && anyReset) begin
          strb.loadLines = 1'b1;
          stateNxt       = ST_HOLD;
          msCntNxt       = '0;
        end
      end
      ST_HOLD: begin
        if (holdDone) begin
          strb.relLines = 1'b1;
          stateNxt      = ST_WAIT;
          msCntNxt      = '0;
        end else if (msTick) begin
          msCntNxt = msCnt + 1'b1;
        end
      end
      ST_WAIT: begin
        if (waitDone) begin
          strb.reinitGo = 1'b1;
          stateNxt      = ST_IDLE;
          msCntNxt      = '0;
        end else if (msTick) begin
          msCntNxt = msCnt + 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      msCnt <= '0;
    end else begin
      state <= stateNxt;
      msCnt <= msCntNxt;
    end
  end

  assign busy = (state != ST_IDLE);

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> (msCnt < CNT_W'(HOLD_MS))); // R7
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (msCnt < CNT_W'(REINIT_MS))); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !msTick) |=> busy); // R9

endmodule

// File: rtl/reset_seq_datapath.sv
module reset_seq_datapath
  import reset_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strb,
  input  logic [RST_BITS-1:0]  resetMask,
  input  logic                 legacyMode,
  output logic [NUM_LINES-1:0] lineOn,
  output logic                 sleepNotify,
  output logic                 reinitPulse
);

  logic [NUM_LINES-1:0] lineReq;

  // which lines each reset kind pulls
  always_comb begin
    lineReq           = '0;
    lineReq[LINE_SOC] = resetMask[CMD_FULL];
    lineReq[LINE_SEC] = resetMask[CMD_FULL] | resetMask[CMD_NORM];
    lineReq[LINE_MEM] = resetMask[CMD_MEM] | (resetMask[CMD_NORM] & legacyMode);
    lineReq[LINE_PWR] = resetMask[CMD_PWR];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineOn      <= '0;
      sleepNotify <= 1'b0;
      reinitPulse <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (strb.loadLines)     lineOn[i] <= lineReq[i];
        else if (strb.relLines) lineOn[i] <= 1'b0;
      end
      sleepNotify <= strb.sleepGo;
      reinitPulse <= strb.reinitGo;
    end
  end

  AST_RELEASE_ALL: assert property (@(posedge clk) disable iff (!rstN)
    strb.relLines |=> (lineOn == '0)); // R7
  AST_SOC_WITH_SEC: assert property (@(posedge clk) disable iff (!rstN)
    lineOn[LINE_SOC] |-> lineOn[LINE_SEC]); // R2
  AST_REINIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    reinitPulse |=> !reinitPulse); // R8
  AST_SLEEP_NO_LINES: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sleepGo && !strb.loadLines && lineOn == '0) |=> (lineOn == '0)); // R6

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import reset_seq_pkg::*;
#(
  parameter int HOLD_MS   = 5,
  parameter int REINIT_MS = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdWrite,
  input  logic [CMD_W-1:0] cmdData,
  input  logic             msTick,
  input  logic             legacyMode,
  output logic             socRstN,
  output logic             secRstN,
  output logic             memRstN,
  output logic             powerOffReq,
  output logic             sleepNotify,
  output logic             reinitPulse,
  output logic             busy
);

  seqStrobe_t           strb;
  logic [NUM_LINES-1:0] lineOn;

  reset_seq_ctrl #(.HOLD_MS(HOLD_MS), .REINIT_MS(REINIT_MS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdWrite (cmdWrite),
    .cmdData  (cmdData),
    .msTick   (msTick),
    .strb     (strb),
    .busy     (busy)
  );

  reset_seq_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .resetMask   (cmdData[RST_BITS-1:0]),
    .legacyMode  (legacyMode),
    .lineOn      (lineOn),
    .sleepNotify (sleepNotify),
    .reinitPulse (reinitPulse)
  );

  assign socRstN     = ~lineOn[LINE_SOC];
  assign secRstN     = ~lineOn[LINE_SEC];
  assign memRstN     = ~lineOn[LINE_MEM];
  assign powerOffReq = lineOn[LINE_PWR];

  AST_LINES_NEED_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!socRstN || !secRstN || !memRstN || powerOffReq) |-> busy); // R9

endmodule

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;

  localparam int HOLD   = 5;
  localparam int REINIT = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdWrite = 1'b0;
  logic [4:0] cmdData = '0;
  logic msTick = 1'b0;
  logic legacyMode = 1'b0;
  logic socRstN, secRstN, memRstN, powerOffReq, sleepNotify, reinitPulse, busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tickPeriod = 7;
  int tickDiv = 0;
  int tickSeen = 0;

  // behavioural reference state
  int   mPhase = 0;
  int   mCnt = 0;
  logic mSoc = 0, mSec = 0, mMem = 0, mPwr = 0, mSleep = 0, mReinit = 0;

  always #4 clk = ~clk;

  reset_sequencer #(.HOLD_MS(HOLD), .REINIT_MS(REINIT)) u_reset_sequencer (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdData(cmdData),
    .msTick(msTick), .legacyMode(legacyMode),
    .socRstN(socRstN), .secRstN(secRstN), .memRstN(memRstN),
    .powerOffReq(powerOffReq), .sleepNotify(sleepNotify),
    .reinitPulse(reinitPulse), .busy(busy)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // timebase
  always @(negedge clk) begin
    if (tickDiv >= tickPeriod - 1) begin
      tickDiv = 0;
      msTick  = 1'b1;
    end else begin
      tickDiv++;
      msTick = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (msTick) tickSeen++;
  end

  // reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCnt = 0;
      mSoc = 0; mSec = 0; mMem = 0; mPwr = 0; mSleep = 0; mReinit = 0;
    end else begin
      mSleep  = 0;
      mReinit = 0;
      if (mPhase == 0) begin
        if (cmdWrite) begin
          if (cmdData[4]) mSleep = 1;
          if (cmdData[3:0] != 0) begin
            mSoc = cmdData[1];
            mSec = cmdData[1] | cmdData[2];
            mMem = cmdData[3] | (cmdData[2] & legacyMode);
            mPwr = cmdData[0];
            mPhase = 1; mCnt = 0;
          end
        end
      end else if (mPhase == 1) begin
        if (msTick) begin
          mCnt++;
          if (mCnt == HOLD) begin
            mSoc = 0; mSec = 0; mMem = 0; mPwr = 0;
            mPhase = 2; mCnt = 0;
          end
        end
      end else begin
        if (msTick) begin
          mCnt++;
          if (mCnt == REINIT) begin
            mReinit = 1; mPhase = 0; mCnt = 0;
          end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(socRstN, !mSoc, "R2 socRstN");
      chk(secRstN, !mSec, "R3 secRstN");
      chk(memRstN, !mMem, "R4 memRstN");
      chk(powerOffReq, mPwr, "R5 powerOffReq");
      chk(sleepNotify, mSleep, "R6 sleepNotify");
      chk(reinitPulse, mReinit, "R8 reinitPulse");
      chk(busy, mPhase != 0, "R9 busy");
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic doWrite(input logic [4:0] c);
    @(negedge clk);
    cmdWrite = 1'b1;
    cmdData  = c;
    @(negedge clk);
    cmdWrite = 1'b0;
    cmdData  = '0;
  endtask

  task automatic waitTicks(input int target);
    while (tickSeen < target) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    // R1: reset values, before and after release of reset
    chk(socRstN, 1'b1, "R1 socRstN");
    chk(powerOffReq, 1'b0, "R1 powerOffReq");
    rstN = 1'b1;
    @(negedge clk);
    chk(secRstN, 1'b1, "R1 secRstN");
    chk(memRstN, 1'b1, "R1 memRstN");
    chk(busy, 1'b0, "R1 busy");
    chk(reinitPulse, 1'b0, "R1 reinitPulse");

    // R2 + R7 + R8: full reboot with exact window edges
    doWrite(5'h02);
    t0 = tickSeen;
    chk(socRstN, 1'b0, "R2 soc asserted");
    chk(secRstN, 1'b0, "R2 sec asserted");
    chk(memRstN, 1'b1, "R2 mem untouched");
    waitTicks(t0 + HOLD - 1);
    chk(socRstN, 1'b0, "R7 still held after 4 ticks");
    waitTicks(t0 + HOLD);
    chk(socRstN, 1'b1, "R7 soc released after 5th tick");
    chk(secRstN, 1'b1, "R7 sec released together");
    waitTicks(t0 + HOLD + REINIT - 1);
    chk(busy, 1'b1, "R8 busy before last tick");
    chk(reinitPulse, 1'b0, "R8 no early pulse");
    waitTicks(t0 + HOLD + REINIT);
    chk(reinitPulse, 1'b1, "R8 pulse after 100th tick");
    chk(busy, 1'b0, "R8 busy falls with pulse");
    waitIdle();

    // R3: normal reboot without and with legacy mode
    legacyMode = 1'b0;
    doWrite(5'h04);
    chk(secRstN, 1'b0, "R3 sec asserted");
    chk(memRstN, 1'b1, "R3 mem high, legacy off");
    waitIdle();
    tickPeriod = 4;
    legacyMode = 1'b1;
    doWrite(5'h04);
    legacyMode = 1'b0;
    repeat (2) @(negedge clk);
    chk(memRstN, 1'b0, "R3 mem low, legacy latched at write");
    waitIdle();

    // R4: memory-only reset
    doWrite(5'h08);
    chk(memRstN, 1'b0, "R4 mem asserted");
    chk(secRstN, 1'b1, "R4 sec untouched");
    chk(socRstN, 1'b1, "R4 soc untouched");
    waitIdle();

    // R5: power-off
    tickPeriod = 9;
    doWrite(5'h01);
    chk(powerOffReq, 1'b1, "R5 power-off request");
    chk(socRstN, 1'b1, "R5 soc untouched");
    waitIdle();

    // R6: sleep notice only
    doWrite(5'h10);
    chk(sleepNotify, 1'b1, "R6 sleep pulse");
    chk(busy, 1'b0, "R6 no busy");
    @(negedge clk);
    chk(sleepNotify, 1'b0, "R6 pulse one cycle");
    chk(secRstN, 1'b1, "R6 no line asserted");

    // R9: write during a sequence is ignored
    tickPeriod = 3;
    doWrite(5'h04);
    repeat (4) @(negedge clk);
    doWrite(5'h1B);
    chk(memRstN, 1'b1, "R9 mem unaffected by busy write");
    chk(socRstN, 1'b1, "R9 soc unaffected by busy write");
    chk(sleepNotify, 1'b0, "R9 sleep ignored while busy");
    waitIdle();

    // R10: combined bits plus sleep, shared hold
    tickPeriod = 5;
    doWrite(5'h1F);
    t0 = tickSeen;
    chk(socRstN, 1'b0, "R10 soc");
    chk(memRstN, 1'b0, "R10 mem");
    chk(powerOffReq, 1'b1, "R10 pwr");
    chk(sleepNotify, 1'b1, "R10 sleep");
    waitTicks(t0 + HOLD);
    chk(memRstN, 1'b1, "R10 mem released together");
    chk(powerOffReq, 1'b0, "R10 pwr released together");
    waitIdle();

    // back-to-back: write in the pulse cycle area after idle
    tickPeriod = 2;
    doWrite(5'h0A);
    waitIdle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule